// File: doc/BRIEF.md
# SPI Slave Byte Engine with Select Framing

This block is the serial side of an SPI peripheral that works only as a slave. A remote master supplies the serial clock. The engine moves one byte out of a transmit holding register and one byte into a receive buffer for every eight clock pulses. Both directions run most-significant bit first. Clock polarity and the choice of which clock edge launches data are both configurable. An active-low select input frames each byte, and a mode field chooses whether that select is obeyed or ignored.

Select, serial clock and serial data are brought into the system clock domain through two-flop synchronizers, and clock edges are detected there. For this to work, the serial clock must run slower than a quarter of the system clock. The host side loads the next byte through a write strobe. It reads the received byte from a buffer and then acknowledges it. The acknowledge clears the completion flag and two sticky error flags. The engine also drives an output-enable for the serial data pin. That enable follows the raw select pin with no synchronizer delay, so the pin is released the moment the master deselects.

Top module: `spiSelectSlave`

## Requirements
- R1: After a synchronous reset, `rxData` is 0 and `byteDone`, `overflow` and `writeColl` are all 0.
- R2: With `modeSel` = 4'b0100, `ssN` low, `clkPhase` = 0 and `clkPol` = 0, the bit on `sdi` is captured at each rising `sclk` edge, MSB first. After the eighth rising edge, `rxData` holds the assembled byte and `byteDone` is 1.
- R3: With `clkPhase` = 0, `sdo` presents bit 7 of the loaded byte as soon as the engine is selected, before any clock edge. Each following bit appears after a trailing (sampling-opposite) edge.
- R4: With `clkPhase` = 1, each output bit is launched by a leading edge and `sdi` is captured on the following trailing edge. Otherwise bytes are transferred as in R2 and R3.
- R5: `clkPol` = 1 makes high the idle level of `sclk` and swaps which physical edge is leading. With that change, transfers behave exactly as with `clkPol` = 0.
- R6: In mode 4'b0100, `sdoOe` is 1 only while `ssN` is low. It falls in the same cycle that `ssN` rises, even in the middle of a byte.
- R7: Raising `ssN` in mode 4'b0100 clears the bit counter and discards the partial byte. The next full byte after reselection is received intact.
- R8: Clearing `enable` clears the bit counter and discards the partial byte in the same way as R7.
- R9: With `modeSel` = 4'b0101, `ssN` is ignored. `sdoOe` is 1 and bytes transfer while `ssN` is high.
- R10: Any configuration other than 4'b0100 or 4'b0101, and `clkPhase` = 1 with any mode other than 4'b0100, is illegal. In an illegal configuration the engine stays idle: `sdoOe` is 0 and no byte completes.
- R11: If a byte completes while `byteDone` is still 1 and is not being acknowledged in that cycle, `overflow` becomes 1 and `rxData` keeps the older byte.
- R12: A `txWrite` while a byte is partly transferred sets `writeColl`. The write is dropped, so the previously loaded byte is the one sent after reselection.
- R13: An `ack` pulse clears `byteDone`, `overflow` and `writeColl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module enable; low holds the counter at zero |
| modeSel | input | 4 | 4'b0100 select-controlled slave, 4'b0101 select ignored |
| clkPol | input | 1 | Idle level of the serial clock |
| clkPhase | input | 1 | 0: sample on leading edge; 1: launch on leading edge |
| sclkIn | input | 1 | Serial clock from the master |
| ssN | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for the serial data pin |
| txData | input | 8 | Byte to transmit |
| txWrite | input | 1 | Load strobe for `txData` |
| rxData | output | 8 | Last accepted received byte |
| byteDone | output | 1 | Sticky byte-complete flag |
| overflow | output | 1 | Sticky receive overflow flag |
| writeColl | output | 1 | Sticky write-collision flag |
| ack | input | 1 | Clears the three flags |

## Verification
The bench walks all four polarity and phase combinations. It checks both the bits seen on `sdo` and the byte assembled from `sdi`. An engine that swapped the sample and launch edges would return bit-shifted bytes. A design that released the pin only after synchronization would leave `sdoOe` high for two cycles after deselection. A counter that survived deselection or a disable would misframe the next byte. The bench also covers a second byte arriving before the first is read, a write while a byte is in flight, and the two forms of illegal configuration. A design that got these wrong would overwrite `rxData`, corrupt the transmit byte, or drive the pin while illegal.

// File: rtl/spiSlvPkg.sv
package spiSlvPkg;
  localparam logic [3:0] MODE_SEL  = 4'b0100;
  localparam logic [3:0] MODE_FREE = 4'b0101;

  typedef struct packed {
    logic sample;
    logic last;
    logic shift;
    logic reload;
    logic idle;
  } spiStrobeT;
endpackage

// File: rtl/spiSlvCtrl.sv
module spiSlvCtrl
  import spiSlvPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic [3:0] modeSel,
  input  logic      clkPol,
  input  logic      clkPhase,
  input  logic      sclkIn,
  input  logic      ssN,
  input  logic      sdi,
  output spiStrobeT stb,
  output logic      sdiSync,
  output logic      busy,
  output logic      sdoOe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_N-1:0] sclkQ, ssQ, sdiQ;
  logic normPrev, norm, selUse, legal, active;
  logic lead, trail, sampleEv, shiftEv, phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkQ    <= '0;
      ssQ      <= '1;
      sdiQ     <= '0;
      normPrev <= 1'b0;
    end else begin
      sclkQ    <= {sclkQ[SYNC_N-2:0], sclkIn};
      ssQ      <= {ssQ[SYNC_N-2:0], ssN};
      sdiQ     <= {sdiQ[SYNC_N-2:0], sdi};
      normPrev <= norm;
    end
  end

  assign norm    = sclkQ[SYNC_N-1] ^ clkPol;
  assign sdiSync = sdiQ[SYNC_N-1];
  assign selUse  = (modeSel == MODE_SEL);
  assign legal   = enable && (selUse || modeSel == MODE_FREE) && !(clkPhase && !selUse);
  assign active  = legal && (!selUse || !ssQ[SYNC_N-1]);
  assign lead    = active && norm && !normPrev;
  assign trail   = active && !norm && normPrev;
  assign sampleEv = clkPhase ? trail : lead;
  assign shiftEv  = clkPhase ? lead : trail;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (sampleEv) begin
      cnt   <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
      phase <= 1'b0;
    end else if (shiftEv && clkPhase) begin
      phase <= 1'b1;
    end
  end

  always_comb begin
    stb.sample = sampleEv;
    stb.last   = sampleEv && (cnt == LAST_BIT);
    stb.shift  = shiftEv && !(!clkPhase && cnt == '0);
    stb.reload = (!clkPhase && shiftEv && cnt == '0) || (clkPhase && stb.last);
    stb.idle   = !active;
  end

  assign busy  = (cnt != '0) || phase;
  assign sdoOe = legal && (!selUse || !ssN);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.sample, stb.shift}));                                  // R2
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (selUse && $rose(ssQ[SYNC_N-1])) |=> (cnt == '0 && !busy));          // R7
endmodule

// File: rtl/spiSlvData.sv
module spiSlvData
  import spiSlvPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  spiStrobeT         stb,
  input  logic              clkPhase,
  input  logic              sdiSync,
  input  logic              busy,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              ack,
  output logic              sdo,
  output logic [DATA_W-1:0] rxData,
  output logic              byteDone,
  output logic              overflow,
  output logic              writeColl
);
  logic [DATA_W-1:0] rxSr, txSr, txBuf, nextRx;
  logic sdoBit, full, wrOk;

  assign nextRx = {rxSr[DATA_W-2:0], sdiSync};
  assign full   = byteDone && !ack;
  assign wrOk   = txWrite && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxSr <= '0; rxData <= '0; txSr <= '0; txBuf <= '0; sdoBit <= 1'b0;
      byteDone <= 1'b0; overflow <= 1'b0; writeColl <= 1'b0;
    end else begin
      if (stb.sample) rxSr <= nextRx;
      if (stb.last) begin
        byteDone <= 1'b1;
        if (full) overflow <= 1'b1;
        else      rxData   <= nextRx;
      end else if (ack) begin
        byteDone <= 1'b0;
        overflow <= 1'b0;
      end
      if (txWrite && busy) writeColl <= 1'b1;
      else if (ack)        writeColl <= 1'b0;
      if (wrOk) txBuf <= txData;
      if (wrOk)                        txSr <= txData;
      else if (stb.idle || stb.reload) txSr <= txBuf;
      else if (stb.shift)              txSr <= {txSr[DATA_W-2:0], 1'b0};
      if (stb.shift && clkPhase) sdoBit <= txSr[DATA_W-1];
    end
  end

  assign sdo = clkPhase ? sdoBit : txSr[DATA_W-1];

  AST_OVF_KEEP: assert property (@(posedge clk) disable iff (rst)
    (stb.last && byteDone && !ack) |=> (overflow && $stable(rxData)));   // R11
  AST_COLL_SET: assert property (@(posedge clk) disable iff (rst)
    (txWrite && busy) |=> writeColl);                                    // R12
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ack && !stb.last && !txWrite) |=> (!byteDone && !overflow && !writeColl)); // R13
endmodule

// File: rtl/spiSelectSlave.sv
module spiSelectSlave
  import spiSlvPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [3:0]        modeSel,
  input  logic              clkPol,
  input  logic              clkPhase,
  input  logic              sclkIn,
  input  logic              ssN,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  output logic [DATA_W-1:0] rxData,
  output logic              byteDone,
  output logic              overflow,
  output logic              writeColl,
  input  logic              ack
);
  spiStrobeT stb;
  logic sdiSync, busy;

  spiSlvCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst(rst), .enable(enable), .modeSel(modeSel), .clkPol(clkPol),
    .clkPhase(clkPhase), .sclkIn(sclkIn), .ssN(ssN), .sdi(sdi), .stb(stb),
    .sdiSync(sdiSync), .busy(busy), .sdoOe(sdoOe)
  );

  spiSlvData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .stb(stb), .clkPhase(clkPhase), .sdiSync(sdiSync),
    .busy(busy), .txData(txData), .txWrite(txWrite), .ack(ack), .sdo(sdo),
    .rxData(rxData), .byteDone(byteDone), .overflow(overflow), .writeColl(writeColl)
  );

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (modeSel == MODE_SEL && ssN) |-> !sdoOe);                            // R6
  AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (clkPhase && modeSel != MODE_SEL) |-> (!sdoOe && !stb.sample));     // R10
endmodule

// File: tb/sim_spiSelectSlave.sv
module sim_spiSelectSlave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, clkPol = 1'b0, clkPhase = 1'b0, sclkIn = 1'b0;
  logic ssN = 1'b1, sdi = 1'b0, txWrite = 1'b0, ack = 1'b0;
  logic [3:0] modeSel = 4'b0100;
  logic [7:0] txData = 8'h00;
  logic sdo, sdoOe, byteDone, overflow, writeColl;
  logic [7:0] rxData;
  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  localparam int HALF = 6;
  // {clkPhase, clkPol, byte loaded for transmit, byte sent by the master}
  localparam logic [17:0] VEC [5] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 8'h00, 8'hFF}
  };

  always #2.5 clk = ~clk;

  spiSelectSlave u0 (
    .clk(clk), .rst(rst), .enable(enable), .modeSel(modeSel), .clkPol(clkPol),
    .clkPhase(clkPhase), .sclkIn(sclkIn), .ssN(ssN), .sdi(sdi), .sdo(sdo),
    .sdoOe(sdoOe), .txData(txData), .txWrite(txWrite), .rxData(rxData),
    .byteDone(byteDone), .overflow(overflow), .writeColl(writeColl), .ack(ack)
  );

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic loadTx(input logic [7:0] b);
    txData = b; txWrite = 1'b1; waitClk(1); txWrite = 1'b0; waitClk(1);
  endtask

  task automatic doAck();
    ack = 1'b1; waitClk(1); ack = 1'b0; waitClk(1);
  endtask

  task automatic setClk(input logic ph, input logic pol);
    clkPhase = ph; clkPol = pol; sclkIn = pol; waitClk(4);
  endtask

  task automatic xfer(input logic [7:0] mosi, input int nbits, output logic [7:0] seen);
    seen = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      if (!clkPhase) begin
        sdi = mosi[7-i]; waitClk(HALF);
        seen[7-i] = sdo;
        sclkIn = ~clkPol; waitClk(HALF);
        sclkIn = clkPol;
      end else begin
        sclkIn = ~clkPol; sdi = mosi[7-i]; waitClk(HALF);
        seen[7-i] = sdo;
        sclkIn = clkPol; waitClk(HALF);
      end
    end
    waitClk(HALF);
  endtask

  initial begin
    logic [7:0] seen;
    waitClk(4);
    rst = 1'b0; waitClk(1);
    check("R1 rxData", rxData, 8'h00);
    check("R1 byteDone", {7'd0, byteDone}, 8'd0);
    check("R1 overflow", {7'd0, overflow}, 8'd0);
    check("R1 writeColl", {7'd0, writeColl}, 8'd0);

    enable = 1'b1; modeSel = 4'b0100; waitClk(2);
    check("R6 idle oe", {7'd0, sdoOe}, 8'd0);

    for (int v = 0; v < 5; v++) begin
      setClk(VEC[v][17], VEC[v][16]);
      loadTx(VEC[v][15:8]);
      ssN = 1'b0; #1;
      check("R6 oe on select", {7'd0, sdoOe}, 8'd1);
      waitClk(4);
      xfer(VEC[v][7:0], 8, seen);
      check("R2 R4 R5 received byte", rxData, VEC[v][7:0]);
      check("R3 R4 R5 transmitted byte", seen, VEC[v][15:8]);
      check("R2 byteDone", {7'd0, byteDone}, 8'd1);
      ssN = 1'b1; waitClk(4);
      doAck();
      check("R13 byteDone cleared", {7'd0, byteDone}, 8'd0);
    end

    // R6, R7: deselect mid-byte, then reselect
    setClk(1'b0, 1'b0);
    loadTx(8'hC6);
    ssN = 1'b0; waitClk(4);
    xfer(8'hFF, 3, seen);
    ssN = 1'b1; #1;
    check("R6 oe released mid-byte", {7'd0, sdoOe}, 8'd0);
    waitClk(6);
    ssN = 1'b0; waitClk(4);
    xfer(8'h3C, 8, seen);
    check("R7 byte after reframe", rxData, 8'h3C);
    check("R7 tx restarts at bit 7", seen, 8'hC6);
    ssN = 1'b1; waitClk(4); doAck();

    // R8: disable mid-byte
    ssN = 1'b0; waitClk(4);
    xfer(8'hFF, 3, seen);
    enable = 1'b0; waitClk(6); enable = 1'b1; waitClk(4);
    xfer(8'h96, 8, seen);
    check("R8 byte after disable", rxData, 8'h96);
    ssN = 1'b1; waitClk(4); doAck();

    // R12: collision, then R13 clears it
    loadTx(8'hA5);
    ssN = 1'b0; waitClk(4);
    xfer(8'h00, 3, seen);
    loadTx(8'h11);
    check("R12 writeColl set", {7'd0, writeColl}, 8'd1);
    ssN = 1'b1; waitClk(6);
    ssN = 1'b0; waitClk(4);
    xfer(8'h42, 8, seen);
    check("R12 old byte kept", seen, 8'hA5);
    ssN = 1'b1; waitClk(4);
    doAck();
    check("R13 writeColl cleared", {7'd0, writeColl}, 8'd0);

    // R11: overflow keeps first byte
    ssN = 1'b0; waitClk(4);
    xfer(8'h5C, 8, seen);
    xfer(8'hE7, 8, seen);
    check("R11 overflow set", {7'd0, overflow}, 8'd1);
    check("R11 rxData kept", rxData, 8'h5C);
    ssN = 1'b1; waitClk(4);
    doAck();
    check("R13 overflow cleared", {7'd0, overflow}, 8'd0);

    // R9: select ignored
    modeSel = 4'b0101; waitClk(2);
    check("R9 oe with ssN high", {7'd0, sdoOe}, 8'd1);
    xfer(8'h6B, 8, seen);
    check("R9 byte with ssN high", rxData, 8'h6B);
    doAck();

    // R10: illegal phase with select off, and an unknown mode
    setClk(1'b1, 1'b0);
    xfer(8'h24, 8, seen);
    check("R10 phase1 without select: oe", {7'd0, sdoOe}, 8'd0);
    check("R10 phase1 without select: no byte", {7'd0, byteDone}, 8'd0);
    setClk(1'b0, 1'b0);
    modeSel = 4'b0000; ssN = 1'b0; waitClk(4);
    xfer(8'h24, 8, seen);
    check("R10 unknown mode: oe", {7'd0, sdoOe}, 8'd0);
    check("R10 unknown mode: no byte", {7'd0, byteDone}, 8'd0);
    check("R10 rxData unchanged", rxData, 8'h6B);

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule